// File: doc/BRIEF.md
# Configurable I2S Audio Transmitter

This block is a master-mode serial audio transmitter. Stereo sample pairs are written into a small transmit queue. A serializer shifts them out on a data line, framed by a bit clock and a word-select clock. The block derives both clocks from its own clock input, which is treated as the root audio clock. The serial framing is chosen at run time through a configuration write. The options are standard I2S, left-justified or right-justified framing, an optional word-select inversion, the sample width, the root-clock-to-frame ratio and the number of bit clocks per frame.

Software fills the queue completely while transmission is stopped, then raises the active control and keeps feeding entries while the full flag is low. A flush pulse discards every queued entry. Each queue entry carries one stereo pair and is consumed at the start of a frame. If the queue runs dry while transmitting, silent frames go out.

The serializer is a two-state machine. In IDLE the bit clock is held low, word select sits at the right-channel level and data is zero. In RUN the bit clock toggles and one bit is sent per falling edge. The transition START (IDLE to RUN) is taken when active is high and pause is low. The transition STOP (RUN to IDLE) is taken as soon as that condition is lost. In both cases the next frame starts afresh from its left slot.

Top module: `i2s_tx_ctrl`

## Requirements
- R1: The queue holds DEPTH entries (8 by default). `fifo_count` reports the number held and starts at 0 after reset. `fifo_full` is high exactly when the count equals DEPTH. A write while full is dropped and never transmitted.
- R2: A one-cycle `fifo_flush` pulse empties the queue, so `fifo_count` reads 0 on the following cycle and the flushed entries are never sent.
- R3: A configuration write updates all fields together.
  - Format code 0 selects I2S, 1 selects left-justified and 2 selects right-justified. Code 3 is refused.
  - Sample width 8, 16 or 24 is accepted. Any other width is refused.
  - A refused field keeps its old value, and `cfg_err` is high for the one cycle after that write.
  - Reset defaults are I2S, no inversion, 16-bit samples, ratio 256 and 32 bit clocks per frame.
- R4: The root ratio accepts 256, 384, 512 or 768. Any other value becomes 256. The bit clock half-period is rfs/(2*bfs) root cycles, rounded down.
- R5: Bit clocks per frame accept 16, 24, 32 or 48. Any other value leaves the previous setting in place.
- R6: In I2S format the left slot has word select low. The sample MSB appears one bit clock after the word-select edge, and the LSB of a slot may spill into the first bit of the following slot.
- R7: In both justified formats the left slot has word select high. Left-justified data starts with the MSB on the edge bit. Right-justified data ends with the LSB on the last bit of the slot. Unused bits are zero.
- R8: The inversion option flips the word-select level that the selected format would use.
- R9: The bit clock toggles only while `tx_active` is high and `tx_pause` is low. Otherwise the bit clock stays low and no entry is consumed.
- R10: An entry carries the left sample in bits [47:24] and the right sample in bits [23:0], each right-aligned to the width. One entry is taken per frame, in write order. An empty queue sends zero samples.
- R11: Data and word select change only on falling bit-clock edges and are stable at each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fmt | input | 2 | Format code: 0 I2S, 1 left-justified, 2 right-justified |
| cfg_ws_inv | input | 1 | Word-select inversion |
| cfg_width | input | 5 | Sample width in bits |
| cfg_rfs | input | 10 | Root clocks per frame |
| cfg_bfs | input | 6 | Bit clocks per frame |
| cfg_err | output | 1 | One-cycle pulse after a refused field |
| tx_active | input | 1 | Transmit enable |
| tx_pause | input | 1 | Transmit hold |
| fifo_flush | input | 1 | Queue flush pulse |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 48 | Stereo pair, left in upper half |
| fifo_full | output | 1 | Queue full |
| fifo_count | output | 4 | Entries in the queue |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sdata | output | 1 | Serial data |

## Verification
The serial stream is decoded back into stereo pairs. Each pair is compared with the pairs written. Distinct left and right patterns are sent in each format so that a swapped channel, a missing one-bit delay or a wrong justification shows up as a value mismatch.

A short write burst followed by silent frames separates correct ordering from underflow handling. Odd configuration values, such as a 12-bit width, format 3, ratio 1000 and 20 bit clocks, are measured through the bit-clock period and the decoded width. These show whether a refused or replaced field took effect. Paused, flushed and overfilled queues show whether entries are consumed or dropped.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S   = 2'd0,
        FMT_LEFT  = 2'd1,
        FMT_RIGHT = 2'd2
    } fmt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ser_state_e;

    typedef struct packed {
        fmt_e       fmt;
        logic       ws_inv;
        logic [4:0] width;
        logic [9:0] rfs;
        logic [5:0] bfs;
    } cfg_t;

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 48,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          wr_ok, rd_ok;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign wr_ok = wr_en && !full && !flush;
    assign rd_ok = pop && !empty && !flush;
    assign head  = mem[rptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (rd_ok) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(wr_ok) - CW'(rd_ok);
        end
    end
endmodule

// File: rtl/i2s_tx_cfg.sv
module i2s_tx_cfg
    import i2s_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [1:0] fmt_in,
    input  logic       inv_in,
    input  logic [4:0] width_in,
    input  logic [9:0] rfs_in,
    input  logic [5:0] bfs_in,
    output cfg_t       cfg,
    output logic       err
);
    logic fmt_ok, width_ok, rfs_ok, bfs_ok;

    always_comb begin
        fmt_ok   = (fmt_in != 2'd3);
        width_ok = (width_in == 5'd8) || (width_in == 5'd16) || (width_in == 5'd24);
        rfs_ok   = (rfs_in == 10'd256) || (rfs_in == 10'd384) ||
                   (rfs_in == 10'd512) || (rfs_in == 10'd768);
        bfs_ok   = (bfs_in == 6'd16) || (bfs_in == 6'd24) ||
                   (bfs_in == 6'd32) || (bfs_in == 6'd48);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.fmt    <= FMT_I2S;
            cfg.ws_inv <= 1'b0;
            cfg.width  <= 5'd16;
            cfg.rfs    <= 10'd256;
            cfg.bfs    <= 6'd32;
            err        <= 1'b0;
        end else begin
            err <= we && !(fmt_ok && width_ok);
            if (we) begin
                if (fmt_ok)   cfg.fmt <= fmt_e'(fmt_in);
                if (width_ok) cfg.width <= width_in;
                if (bfs_ok)   cfg.bfs <= bfs_in;
                cfg.ws_inv <= inv_in;
                cfg.rfs    <= rfs_ok ? rfs_in : 10'd256;
            end
        end
    end
endmodule

// File: rtl/i2s_tx_serdes.sv
module i2s_tx_serdes
    import i2s_tx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    localparam int EW      = 2 * SAMPLE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_ok,
    input  cfg_t          cfg,
    input  logic          fifo_empty,
    input  logic [EW-1:0] fifo_head,
    output logic          pop,
    output logic          bclk,
    output logic          ws,
    output logic          sdata
);
    ser_state_e state_q, state_d;

    logic [9:0]          cnt_q, half, half_m1;
    logic [5:0]          pos_q, pos_n, slot, off, sh_lj, sh_rj;
    logic [EW-1:0]       smp_q, smp_n;
    logic [SAMPLE_W-1:0] chan, lj_vec, rj_vec;
    logic                lj_q, lj_n, rj_n, right_n, fall_evt, new_frame, ws_left;

    always_comb begin
        half      = cfg.rfs / 10'({cfg.bfs, 1'b0});
        half_m1   = half - 10'd1;
        slot      = cfg.bfs >> 1;
        ws_left   = (cfg.fmt != FMT_I2S) ^ cfg.ws_inv;
        fall_evt  = (cnt_q == half_m1) && bclk;
        pos_n     = (pos_q >= cfg.bfs - 6'd1) ? '0 : pos_q + 6'd1;
        new_frame = (pos_n == '0);
        smp_n     = new_frame ? (fifo_empty ? '0 : fifo_head) : smp_q;
        right_n   = (pos_n >= slot);
        off       = right_n ? pos_n - slot : pos_n;
        chan      = right_n ? smp_n[SAMPLE_W-1:0] : smp_n[EW-1:SAMPLE_W];
        sh_lj     = 6'(cfg.width) - 6'd1 - off;
        sh_rj     = slot - 6'd1 - off;
        lj_vec    = chan >> sh_lj;
        rj_vec    = chan >> sh_rj;
        lj_n      = (off < 6'(cfg.width)) ? lj_vec[0] : 1'b0;
        rj_n      = ({1'b0, off} + 7'(cfg.width) >= {1'b0, slot}) ? rj_vec[0] : 1'b0;
    end

    // Transitions: START (IDLE->RUN) on run_ok, STOP (RUN->IDLE) when run_ok drops
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (run_ok)  state_d = ST_RUN;
            ST_RUN:  if (!run_ok) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign pop = (state_d == ST_RUN) && fall_evt && new_frame && !fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bclk  <= 1'b0;
            pos_q <= '0;
            smp_q <= '0;
            lj_q  <= 1'b0;
            sdata <= 1'b0;
            ws    <= 1'b0;
        end else begin
            unique case (state_d)
                ST_IDLE: begin
                    cnt_q <= '0;
                    bclk  <= 1'b0;
                    pos_q <= cfg.bfs - 6'd1;
                    smp_q <= '0;
                    lj_q  <= 1'b0;
                    sdata <= 1'b0;
                    ws    <= ~ws_left;
                end
                ST_RUN: begin
                    if (cnt_q >= half_m1) begin
                        cnt_q <= '0;
                        bclk  <= ~bclk;
                        if (fall_evt) begin
                            pos_q <= pos_n;
                            smp_q <= smp_n;
                            lj_q  <= lj_n;
                            ws    <= right_n ? ~ws_left : ws_left;
                            unique case (cfg.fmt)
                                FMT_I2S:   sdata <= lj_q;
                                FMT_LEFT:  sdata <= lj_n;
                                FMT_RIGHT: sdata <= rj_n;
                                default:   sdata <= 1'b0;
                            endcase
                        end
                    end else begin
                        cnt_q <= cnt_q + 10'd1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/i2s_tx_ctrl.sv
module i2s_tx_ctrl
    import i2s_tx_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int SAMPLE_W = 24,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int EW      = 2 * SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_fmt,
    input  logic             cfg_ws_inv,
    input  logic [4:0]       cfg_width,
    input  logic [9:0]       cfg_rfs,
    input  logic [5:0]       cfg_bfs,
    output logic             cfg_err,
    input  logic             tx_active,
    input  logic             tx_pause,
    input  logic             fifo_flush,
    input  logic             wr_en,
    input  logic [EW-1:0]    wr_data,
    output logic             fifo_full,
    output logic [CNT_W-1:0] fifo_count,
    output logic             bclk,
    output logic             ws,
    output logic             sdata
);
    cfg_t          cfg;
    logic          pop, empty;
    logic [EW-1:0] head;

    i2s_tx_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .fmt_in(cfg_fmt), .inv_in(cfg_ws_inv),
        .width_in(cfg_width), .rfs_in(cfg_rfs), .bfs_in(cfg_bfs), .cfg(cfg), .err(cfg_err)
    );

    i2s_tx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .wr_en(wr_en), .wr_data(wr_data),
        .pop(pop), .head(head), .empty(empty), .full(fifo_full), .count(fifo_count)
    );

    i2s_tx_serdes #(.SAMPLE_W(SAMPLE_W)) u_ser (
        .clk(clk), .rst_n(rst_n), .run_ok(tx_active && !tx_pause), .cfg(cfg),
        .fifo_empty(empty), .fifo_head(head), .pop(pop), .bclk(bclk), .ws(ws), .sdata(sdata)
    );
endmodule

// File: rtl/i2s_tx_chk.sv
module i2s_tx_chk #(
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             cfg_err,
    input logic             tx_active,
    input logic             tx_pause,
    input logic             fifo_flush,
    input logic             fifo_full,
    input logic [CNT_W-1:0] fifo_count,
    input logic             bclk,
    input logic             ws,
    input logic             sdata
);
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH)); // R1

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !fifo_flush) |=> fifo_count <= $past(fifo_count)); // R1

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> fifo_count == '0); // R2

    AST_ERR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(cfg_we)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_active && !tx_pause) |=> !bclk); // R9

    AST_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> ($stable(sdata) && $stable(ws))); // R11
endmodule

bind i2s_tx_ctrl i2s_tx_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_i2s_tx_ctrl.sv
module tb_i2s_tx_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        cfg_ws_inv = 1'b0;
    logic [4:0]  cfg_width = 5'd16;
    logic [9:0]  cfg_rfs = 10'd256;
    logic [5:0]  cfg_bfs = 6'd32;
    logic        cfg_err;
    logic        tx_active = 1'b0;
    logic        tx_pause = 1'b0;
    logic        fifo_flush = 1'b0;
    logic        wr_en = 1'b0;
    logic [47:0] wr_data = '0;
    logic        fifo_full;
    logic [3:0]  fifo_count;
    logic        bclk, ws, sdata;

    i2s_tx_ctrl dut (.*);

    always #2.5 clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 0;

    // model of the configuration, derived from the requirements
    int m_fmt = 0, m_inv = 0, m_width = 16, m_rfs = 256, m_bfs = 32;
    int tb_cnt = 0;
    string sb_tag = "R6";
    logic [47:0] exp_q[$];

    // monitor state
    logic wsb [64];
    logic sdb [64];
    int   m_idx = 0, frames = 0;
    bit   m_have = 0;
    logic m_prev = 1'b0;

    function automatic logic left_lvl();
        return logic'((m_fmt != 0) ^ (m_inv != 0));
    endfunction

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic sbit(int q, logic extra);
        if (m_fmt == 0) return (q < m_bfs - 1) ? sdb[q + 1] : extra;
        return sdb[q];
    endfunction

    task automatic finish_frame(logic extra);
        logic [23:0] l = '0, r = '0, msk;
        logic [47:0] e;
        int slot = m_bfs / 2;
        bit ws_ok = 1;
        for (int o = 0; o < slot; o++) begin
            if (m_fmt != 2) begin
                if (o < m_width) begin
                    l[m_width - 1 - o] = sbit(o, extra);
                    r[m_width - 1 - o] = sbit(o + slot, extra);
                end
            end else if (o >= slot - m_width) begin
                l[slot - 1 - o] = sbit(o, extra);
                r[slot - 1 - o] = sbit(o + slot, extra);
            end
        end
        for (int q = 0; q < m_idx && q < 64; q++)
            if (wsb[q] != ((q < slot) ? left_lvl() : !left_lvl())) ws_ok = 0;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : '0;
        msk = 24'((25'd1 << m_width) - 25'd1);
        chk(m_idx == m_bfs, sb_tag, "frame length", m_idx, m_bfs);
        chk(ws_ok, sb_tag, "word-select level", ws_ok, 1);
        chk({l, r} == {e[47:24] & msk, e[23:0] & msk}, sb_tag, "decoded pair",
            {l, r}, {e[47:24] & msk, e[23:0] & msk});
        frames++;
    endtask

    // scoreboard monitor: decodes one frame at each new left slot
    always @(posedge bclk) begin
        if (ws == left_lvl() && m_prev != left_lvl()) begin
            if (m_have) finish_frame(sdata);
            m_idx  = 0;
            m_have = 1;
        end
        if (m_idx < 64) begin
            wsb[m_idx] = ws;
            sdb[m_idx] = sdata;
            m_idx++;
        end
        m_prev = ws;
    end

    task automatic mon_clear();
        m_idx  = 0;
        m_have = 0;
        m_prev = !left_lvl();
        frames = 0;
    endtask

    task automatic cfg_write(int fmt, int inv, int width, int rfs, int bfs, output logic err);
        @(negedge clk);
        cfg_we = 1; cfg_fmt = 2'(fmt); cfg_ws_inv = 1'(inv);
        cfg_width = 5'(width); cfg_rfs = 10'(rfs); cfg_bfs = 6'(bfs);
        @(negedge clk);
        cfg_we = 0;
        err = cfg_err;
        if (fmt != 3) m_fmt = fmt;
        m_inv = inv;
        if (width == 8 || width == 16 || width == 24) m_width = width;
        m_rfs = (rfs == 256 || rfs == 384 || rfs == 512 || rfs == 768) ? rfs : 256;
        if (bfs == 16 || bfs == 24 || bfs == 32 || bfs == 48) m_bfs = bfs;
    endtask

    // driver: writes a pair and pushes what must come out
    task automatic push(logic [23:0] l, logic [23:0] r);
        @(negedge clk);
        wr_en = 1; wr_data = {l, r};
        @(negedge clk);
        wr_en = 0;
        if (tb_cnt < 8) begin
            exp_q.push_back({l, r});
            tb_cnt++;
        end
    endtask

    task automatic run_frames(int n);
        mon_clear();
        @(negedge clk);
        tx_active = 1;
        while (frames < n) @(negedge clk);
        tx_active = 0;
        tb_cnt = 0;
        @(negedge clk);
        chk(exp_q.size() == 0, "R10", "pairs left unsent", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic measure(output int c);
        logic p;
        mon_clear();
        @(negedge clk);
        tx_active = 1;
        do begin p = bclk; @(negedge clk); end while (!(bclk && !p));
        c = 0;
        do begin p = bclk; @(negedge clk); c++; end while (!(bclk && !p));
        tx_active = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic err;
        int per;
        bit quiet;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(fifo_count == 0 && !fifo_full, "R1", "reset queue", fifo_count, 0);
        chk(!bclk && !sdata && !cfg_err, "R9", "reset outputs", {bclk, sdata, cfg_err}, 0);

        // R6: default I2S, 16-bit, 256, 32; R10 underflow zeros afterwards
        sb_tag = "R6";
        push(24'h00A5C3, 24'h001234);
        push(24'h008001, 24'h007FFE);
        push(24'h00FFFF, 24'h000000);
        run_frames(5);

        // R1 fill, overfill; R2 flush
        for (int i = 0; i < 9; i++) push(24'(i + 1), 24'(16 - i));
        chk(fifo_count == 8 && fifo_full, "R1", "full count", fifo_count, 8);
        @(negedge clk);
        fifo_flush = 1;
        @(negedge clk);
        fifo_flush = 0;
        chk(fifo_count == 0 && !fifo_full, "R2", "after flush", fifo_count, 0);
        exp_q.delete(); tb_cnt = 0;
        sb_tag = "R2";
        run_frames(2);

        // R1 dropped overflow write is never sent
        sb_tag = "R1";
        for (int i = 0; i < 9; i++) push(24'(i * 3 + 1), 24'(i * 5 + 2));
        run_frames(10);

        // R7 left-justified 24-bit, 768/48
        cfg_write(1, 0, 24, 768, 48, err);
        chk(!err, "R3", "valid write error flag", err, 0);
        sb_tag = "R7";
        push(24'hC0FFEE, 24'h123456);
        push(24'h800001, 24'h7FFFFE);
        run_frames(3);
        measure(per);
        chk(per == 16, "R4", "period 768/48", per, 16);

        // R7 right-justified 16-bit in 24-bit slots
        cfg_write(2, 0, 16, 768, 48, err);
        push(24'h00BEEF, 24'h004321);
        push(24'h000001, 24'h008000);
        run_frames(3);

        // R3 refused width and format keep the old values
        cfg_write(2, 0, 12, 768, 48, err);
        chk(err, "R3", "width 12 refused", err, 1);
        cfg_write(3, 0, 16, 768, 48, err);
        chk(err, "R3", "format 3 refused", err, 1);
        sb_tag = "R3";
        push(24'h00F00F, 24'h000FF0);
        run_frames(2);

        // R4 ratio fallback, R5 bit clocks unchanged
        cfg_write(1, 0, 16, 512, 32, err);
        measure(per);
        chk(per == 16, "R4", "period 512/32", per, 16);
        cfg_write(1, 0, 16, 1000, 20, err);
        measure(per);
        chk(per == 8, "R5", "period after 1000/20", per, 8);

        // R8 inverted word select in I2S
        cfg_write(0, 1, 16, 256, 32, err);
        sb_tag = "R8";
        push(24'h00ABCD, 24'h005432);
        run_frames(2);

        // R9 pause holds everything
        push(24'h001111, 24'h002222);
        push(24'h003333, 24'h004444);
        mon_clear();
        @(negedge clk);
        tx_pause = 1; tx_active = 1;
        quiet = 1;
        repeat (200) begin @(negedge clk); if (bclk) quiet = 0; end
        chk(quiet, "R9", "bclk while paused", quiet, 1);
        chk(fifo_count == 2, "R9", "count while paused", fifo_count, 2);
        tx_active = 0; tx_pause = 0;
        sb_tag = "R9";
        run_frames(3);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule